// File: doc/BRIEF.md
# Compare-Match Toggle Pulse Timer

This block is a 16-bit up-counting timer that produces a square wave. A free-standing output flip-flop inverts each time the counter equals a programmed compare value, so the pulse frequency is half the match frequency. The counter either returns to zero on each match, which gives a match period of compare value plus one count ticks, or it runs freely and wraps through its full range.

Software controls the block through a small register port. A control word holds a count enable, a clock-source field, a prescaler field, the counter-clear-source bit, a mode bit and an output-clear bit. A second word holds the compare value. The counter value can be read back. After reset the output is held low by the output-clear bit. Software must release the output-clear bit only while counting is disabled. The bit itself can be written at any time.

The prescaler does not divide the clock. It produces a single-cycle count tick once every 1, 2, 4 or 8 system clocks. Only the system clock is modelled as a count source. Any other clock-source code gives no ticks, so the counter holds its value.

Top module: `cmt_pulse_timer`

## Requirements
- R1: After reset the control word reads 0x0080 (output-clear set, all other fields 0), the compare word reads 0, the counter reads 0 and the pulse output is low.
- R2: While control bit 7 (output-clear) is 1, the pulse output is low, whether counting is enabled or not. The output goes low in the first cycle after the write that sets the bit.
- R3: While control bit 0 (enable) is 0, the counter holds its value.
- R4: With control bit 5 (clear on match) set to 1, the counter returns to 0 on the tick where it equals the compare value. Successive matches are therefore (compare+1) ticks apart. With compare 79 and divide-by-1, the output toggles every 80 clocks.
- R5: With control bit 6 (mode) set to 0, the output inverts on every match, so one full output period spans two match intervals (160 clocks for compare 79).
- R6: Control bits 4:3 select the tick rate: 00, 01, 10 and 11 give one tick every 1, 2, 4 and 8 system clocks.
- R7: With control bit 5 set to 0, the counter wraps from 0xFFFF to 0 and the output still toggles on each match, once every 65536 ticks.
- R8: When enable changes from 0 to 1, the counter restarts from 0 (it reads 0 two cycles after the write). The output keeps its current level.
- R9: With control bit 6 set to 1, the pulse output stays low.
- R10: Control bits 2:1 select the clock source. Code 00 is the system clock. Any other code gives no count ticks, so the counter stays at 0 after start.
- R11: Address 0 holds the control word (bits 15:8 read 0), address 1 holds the compare word and address 2 reads the counter. Writes to address 2 or 3 have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, also the count clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Register write address |
| wr_data | input | 16 | Register write data |
| rd_addr | input | 2 | Register read address |
| rd_data | output | 16 | Register read data (combinational) |
| pulse_out | output | 1 | Square-wave pulse output |

## Verification
Assertions check, on every cycle, the properties that relate state over one cycle:
- the counter holds while enable is off;
- the counter returns to zero on a clearing match or on a wrap;
- a start zeroes the counter and leaves the output level unchanged;
- the output stays low under output-clear and in the mode with bit 6 set;
- a divided tick never fires on two cycles in a row.

Only the bench scenarios can show the timing that emerges over many cycles:
- the 80-clock toggle interval and 160-clock period;
- the scaled intervals for each prescaler code;
- the 65536-tick wrap interval;
- that a non-system clock source never counts;
- the register map readback.

// File: rtl/tmr_pkg.sv
package tmr_pkg;

  typedef struct packed {
    logic       out_clr;  // bit 7
    logic       pwm;      // bit 6
    logic       clr_src;  // bit 5
    logic [1:0] psel;     // bits 4:3
    logic [1:0] csel;     // bits 2:1
    logic       en;       // bit 0
  } ctrl_t;

  localparam int CTRL_W = 8;

  localparam logic [1:0] ADDR_CTRL = 2'd0;
  localparam logic [1:0] ADDR_CMP  = 2'd1;
  localparam logic [1:0] ADDR_CNT  = 2'd2;

  localparam logic [1:0] SRC_SYS = 2'b00;

  localparam ctrl_t CTRL_RST = '{out_clr: 1'b1, pwm: 1'b0, clr_src: 1'b0,
                                 psel: 2'b00, csel: 2'b00, en: 1'b0};

endpackage

// File: rtl/tmr_rst_sync.sv
module tmr_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);

  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= {sync_q[STAGES-2:0], 1'b1};
  end

  assign rst_n_sync = sync_q[STAGES-1];

endmodule

// File: rtl/tmr_regs.sv
module tmr_regs
  import tmr_pkg::*;
#(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         wr_en,
  input  logic [1:0]   wr_addr,
  input  logic [W-1:0] wr_data,
  output ctrl_t        ctrl,
  output logic [W-1:0] cmp
);

  ctrl_t        ctrl_q, ctrl_d;
  logic [W-1:0] cmp_q, cmp_d;
  logic         ctrl_we, cmp_we;

  assign ctrl_we = wr_en && (wr_addr == ADDR_CTRL);
  assign cmp_we  = wr_en && (wr_addr == ADDR_CMP);

  always_comb begin
    ctrl_d = ctrl_q;
    cmp_d  = cmp_q;
    if (ctrl_we) ctrl_d = ctrl_t'(wr_data[CTRL_W-1:0]);
    if (cmp_we)  cmp_d  = wr_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q <= CTRL_RST;
      cmp_q  <= '0;
    end else begin
      ctrl_q <= ctrl_d;
      cmp_q  <= cmp_d;
    end
  end

  assign ctrl = ctrl_q;
  assign cmp  = cmp_q;

  // R11: the compare word changes only through a write to its address
  a_r11_cmp_write_only: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr_en && wr_addr == ADDR_CMP) |=> $stable(cmp_q));

endmodule

// File: rtl/tmr_tick_gen.sv
module tmr_tick_gen
  import tmr_pkg::*;
#(
  parameter int PSEL_W = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en,
  input  logic              start,
  input  logic [1:0]        csel,
  input  logic [PSEL_W-1:0] psel,
  output logic              tick
);

  localparam int MAX_DIV = 1 << ((1 << PSEL_W) - 1);
  localparam int PC_W    = (MAX_DIV > 1) ? $clog2(MAX_DIV) : 1;

  logic [PC_W-1:0] pc_q, pc_d, lim;
  logic            src_ok, wrap;

  // divide ratio 2**psel, so the last phase is 2**psel - 1
  assign lim    = PC_W'((1 << psel) - 1);
  assign src_ok = (csel == SRC_SYS);
  assign wrap   = (pc_q == lim);

  always_comb begin
    pc_d = pc_q;
    if (!en || start)   pc_d = '0;
    else if (src_ok)    pc_d = wrap ? '0 : pc_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pc_q <= '0;
    else        pc_q <= pc_d;
  end

  assign tick = en && !start && src_ok && wrap;

  // R6: any divided rate never yields ticks on two adjacent cycles
  a_r6_no_adjacent_tick: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && psel != '0) |=> (!tick || psel == '0));

  // R10: no tick from a source other than the system clock
  a_r10_no_foreign_tick: assert property (@(posedge clk) disable iff (!rst_n)
    (csel != SRC_SYS) |-> !tick);

endmodule

// File: rtl/tmr_count_core.sv
module tmr_count_core
  import tmr_pkg::*;
#(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  ctrl_t        ctrl,
  input  logic [W-1:0] cmp,
  input  logic         tick,
  output logic         start,
  output logic [W-1:0] cnt,
  output logic         pulse_out
);

  logic         en_d_q;
  logic [W-1:0] cnt_q, cnt_d;
  logic         ff_q, ff_d;
  logic         match, match_tick;

  assign start      = ctrl.en && !en_d_q;
  assign match      = (cnt_q == cmp);
  assign match_tick = tick && match;

  // counter: restart on enable, clear or wrap on a ticked match
  always_comb begin
    cnt_d = cnt_q;
    if (start)                        cnt_d = '0;
    else if (match_tick && ctrl.clr_src) cnt_d = '0;
    else if (tick)                    cnt_d = cnt_q + 1'b1;
  end

  // output flip-flop: cleared by out_clr, toggled on match in toggle mode
  always_comb begin
    ff_d = ff_q;
    if (ctrl.out_clr)                 ff_d = 1'b0;
    else if (match_tick && !ctrl.pwm) ff_d = ~ff_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_d_q <= 1'b0;
      cnt_q  <= '0;
      ff_q   <= 1'b0;
    end else begin
      en_d_q <= ctrl.en;
      cnt_q  <= cnt_d;
      ff_q   <= ff_d;
    end
  end

  assign cnt       = cnt_q;
  assign pulse_out = ff_q && !ctrl.out_clr && !ctrl.pwm;

  // R3: counter frozen while counting is disabled
  a_r3_hold_when_off: assert property (@(posedge clk) disable iff (!rst_n)
    !ctrl.en |=> $stable(cnt_q));

  // R4: clearing match returns the counter to zero
  a_r4_clear_on_match: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && ctrl.clr_src && cnt_q == cmp) |=> (cnt_q == '0));

  // R7: free-running counter wraps to zero
  a_r7_wrap: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && !ctrl.clr_src && cnt_q == '1) |=> (cnt_q == '0));

  // R8: start zeroes the counter and keeps the output level
  a_r8_restart_zero: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> (cnt_q == '0));
  a_r8_restart_level: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !ctrl.out_clr) |=> $stable(ff_q));

endmodule

// File: rtl/cmt_pulse_timer.sv
module cmt_pulse_timer
  import tmr_pkg::*;
#(
  parameter int W      = 16,
  parameter int PSEL_W = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         wr_en,
  input  logic [1:0]   wr_addr,
  input  logic [W-1:0] wr_data,
  input  logic [1:0]   rd_addr,
  output logic [W-1:0] rd_data,
  output logic         pulse_out
);

  localparam int PAD_W = W - CTRL_W;

  logic         rst_n_s;
  ctrl_t        ctrl;
  logic [W-1:0] cmp, cnt;
  logic         tick, start;

  tmr_rst_sync #(.STAGES(2)) u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_n_sync (rst_n_s)
  );

  tmr_regs #(.W(W)) u_regs (
    .clk     (clk),
    .rst_n   (rst_n_s),
    .wr_en   (wr_en),
    .wr_addr (wr_addr),
    .wr_data (wr_data),
    .ctrl    (ctrl),
    .cmp     (cmp)
  );

  tmr_tick_gen #(.PSEL_W(PSEL_W)) u_tick (
    .clk   (clk),
    .rst_n (rst_n_s),
    .en    (ctrl.en),
    .start (start),
    .csel  (ctrl.csel),
    .psel  (ctrl.psel[PSEL_W-1:0]),
    .tick  (tick)
  );

  tmr_count_core #(.W(W)) u_core (
    .clk       (clk),
    .rst_n     (rst_n_s),
    .ctrl      (ctrl),
    .cmp       (cmp),
    .tick      (tick),
    .start     (start),
    .cnt       (cnt),
    .pulse_out (pulse_out)
  );

  always_comb begin
    unique case (rd_addr)
      ADDR_CTRL: rd_data = {{PAD_W{1'b0}}, ctrl};
      ADDR_CMP:  rd_data = cmp;
      ADDR_CNT:  rd_data = cnt;
      default:   rd_data = '0;
    endcase
  end

  // R2: output-clear keeps the pin low
  a_r2_clear_low: assert property (@(posedge clk) disable iff (!rst_n_s)
    ctrl.out_clr |-> !pulse_out);

  // R9: mode bit set keeps the pin low
  a_r9_pwm_low: assert property (@(posedge clk) disable iff (!rst_n_s)
    ctrl.pwm |-> !pulse_out);

endmodule

// File: tb/cmt_pulse_timer_bench.sv
`timescale 1ns/1ps
module cmt_pulse_timer_bench;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [1:0]  wr_addr = '0;
  logic [15:0] wr_data = '0;
  logic [1:0]  rd_addr = '0;
  logic [15:0] rd_data;
  logic        pulse_out;

  int n_chk = 0;
  int n_bad = 0;
  int cyc   = 0;

  always #2.5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  cmt_pulse_timer u_cmt_pulse_timer (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data),
    .pulse_out(pulse_out)
  );

  // control word: [7] out_clr [6] mode [5] clr_src [4:3] psel [2:1] csel [0] en
  function automatic logic [15:0] cw(bit oc, bit pm, bit cs, logic [1:0] ps,
                                     logic [1:0] src, bit en);
    return {8'h00, oc, pm, cs, ps, src, en};
  endfunction

  task automatic check(bit ok, string req, longint act, longint exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wr(logic [1:0] a, logic [15:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(logic [1:0] a, output logic [15:0] d);
    rd_addr = a;
    #0.5;
    d = rd_data;
  endtask

  // counts clocks until pulse_out changes, sampled at falling edges
  task automatic wait_toggle(int lim, output int n);
    logic lvl = pulse_out;
    n = 0;
    while (pulse_out == lvl && n < lim) begin
      @(negedge clk);
      n++;
    end
  endtask

  task automatic stay_low(int n, string req);
    bit bad = 0;
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      if (pulse_out) bad = 1;
    end
    check(!bad, req, bad, 0);
  endtask

  task automatic t_reset;
    logic [15:0] d;
    rd(2'd0, d); check(d == 16'h0080, "R1 ctrl", d, 16'h0080);
    rd(2'd1, d); check(d == 0, "R1 cmp", d, 0);
    rd(2'd2, d); check(d == 0, "R1 cnt", d, 0);
    check(pulse_out == 0, "R1 pulse", pulse_out, 0);
  endtask

  task automatic t_regmap;
    logic [15:0] d;
    wr(2'd1, 16'h1234);
    rd(2'd1, d); check(d == 16'h1234, "R11 cmp readback", d, 16'h1234);
    wr(2'd0, 16'hFF9A);
    rd(2'd0, d); check(d == 16'h009A, "R11 ctrl readback", d, 16'h009A);
    wr(2'd0, cw(1, 0, 0, 0, 0, 0));
    wr(2'd2, 16'h5555);
    rd(2'd2, d); check(d == 0, "R11 cnt not writable", d, 0);
    wr(2'd3, 16'hAAAA);
    rd(2'd1, d); check(d == 16'h1234, "R11 addr3 ignored", d, 16'h1234);
  endtask

  task automatic t_clear_held;
    wr(2'd1, 16'd3);
    wr(2'd0, cw(1, 0, 1, 0, 0, 1));
    stay_low(100, "R2 held low while running");
    wr(2'd0, cw(1, 0, 1, 0, 0, 0));
  endtask

  task automatic t_basic;
    int a, b, n;
    wr(2'd1, 16'd79);
    wr(2'd0, cw(0, 0, 1, 0, 0, 0));
    wr(2'd0, cw(0, 0, 1, 0, 0, 1));
    wait_toggle(400, n);
    wait_toggle(400, a);
    wait_toggle(400, b);
    check(a == 80, "R4 toggle interval", a, 80);
    check(a + b == 160, "R5 full period", a + b, 160);
  endtask

  task automatic t_force_clear;
    int n;
    logic [15:0] d;
    if (!pulse_out) wait_toggle(400, n);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = 2'd0; wr_data = cw(1, 0, 1, 0, 0, 1);
    @(negedge clk);
    wr_en = 1'b0;
    check(pulse_out == 0, "R2 immediate low", pulse_out, 0);
    stay_low(200, "R2 low while counting");
    rd(2'd2, d);
    check(d <= 79, "R2 counter still runs", d, 79);
  endtask

  task automatic t_hold;
    logic [15:0] a, b;
    wr(2'd1, 16'd1000);
    wr(2'd0, cw(1, 0, 1, 0, 0, 0));
    wr(2'd0, cw(0, 0, 1, 0, 0, 1));
    repeat (37) @(negedge clk);
    wr(2'd0, cw(0, 0, 1, 0, 0, 0));
    rd(2'd2, a);
    repeat (25) @(negedge clk);
    rd(2'd2, b);
    check(a == b && a != 0, "R3 counter held", b, a);
  endtask

  task automatic t_restart;
    logic [15:0] d;
    logic lvl;
    lvl = pulse_out;
    @(negedge clk);
    wr_en = 1'b1; wr_addr = 2'd0; wr_data = cw(0, 0, 1, 0, 0, 1);
    @(negedge clk);
    wr_en = 1'b0;
    @(negedge clk);
    rd(2'd2, d);
    check(d == 0, "R8 restart from zero", d, 0);
    check(pulse_out == lvl, "R8 level kept", pulse_out, lvl);
  endtask

  task automatic t_presc;
    int n, a;
    for (int p = 1; p < 4; p++) begin
      wr(2'd0, cw(1, 0, 1, 0, 0, 0));
      wr(2'd1, 16'd9);
      wr(2'd0, cw(0, 0, 1, 2'(p), 0, 0));
      wr(2'd0, cw(0, 0, 1, 2'(p), 0, 1));
      wait_toggle(400, n);
      wait_toggle(400, a);
      check(a == 10 * (1 << p), $sformatf("R6 prescale code %0d", p),
            a, 10 * (1 << p));
    end
  endtask

  task automatic t_freerun;
    int n, a;
    wr(2'd0, cw(1, 0, 0, 0, 0, 0));
    wr(2'd1, 16'd5);
    wr(2'd0, cw(0, 0, 0, 0, 0, 0));
    wr(2'd0, cw(0, 0, 0, 0, 0, 1));
    wait_toggle(100, n);
    wait_toggle(70000, a);
    check(a == 65536, "R7 wrap interval", a, 65536);
  endtask

  task automatic t_pwm;
    wr(2'd0, cw(0, 0, 1, 0, 0, 0));
    wr(2'd1, 16'd9);
    wr(2'd0, cw(0, 1, 1, 0, 0, 1));
    stay_low(300, "R9 mode bit low");
  endtask

  task automatic t_clksrc;
    logic [15:0] d;
    wr(2'd0, cw(1, 0, 1, 0, 0, 0));
    wr(2'd0, cw(0, 0, 1, 0, 2'b01, 1));
    repeat (50) @(negedge clk);
    rd(2'd2, d);
    check(d == 0, "R10 no count from other source", d, 0);
  endtask

  task automatic finish_run;
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  endtask

  initial begin
    wait (cyc >= 190000);
    check(0, "watchdog", cyc, 190000);
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    t_reset();
    t_regmap();
    t_clear_held();
    t_basic();
    t_force_clear();
    t_hold();
    t_restart();
    t_presc();
    t_freerun();
    t_pwm();
    t_clksrc();
    finish_run();
  end

endmodule